// File: doc/BRIEF.md
# Banked Table Window Bridge

This block gives a host, through eight 32-bit registers on a simple register bus, indirect access to two internal memories. One is a table of 128-bit entries; the other is a byte-wide buffer memory. The host loads up to four data words and four bit-enable words, then writes a command word. The command word holds a direction bit, a target bit and an address. Each command runs as one fixed-length transfer, and a sticky completion flag reports the end of it.

A table read copies the addressed entry into the four data registers. A table write is a read-modify-write: every bit of the stored entry takes the matching data register bit where the enable bit is 1 and keeps its old value where the enable bit is 0. Buffer transfers move one byte through the low byte of data register 0.

The transfer engine is a four-state machine. In `ST_IDLE` it waits and accepts a command. `ST_IDLE -> ST_FETCH` happens on an accepted command write. In `ST_FETCH` a synchronous read of the target is issued, and the machine always moves on: `ST_FETCH -> ST_APPLY`. In `ST_APPLY` the merged word or byte is written, or the read data is loaded into the data registers, and the machine always moves on: `ST_APPLY -> ST_FINISH`. In `ST_FINISH` the completion flag is set, and the machine always returns: `ST_FINISH -> ST_IDLE`.

Top module: `ctab_window`

## Requirements
- R1: After reset, all of the following read as zero: the control register (byte offset 0x00), the command register (0x04), data registers 0–3 (0x10, 0x14, 0x18, 0x1C) and enable registers 0–3 (0x20, 0x24, 0x28, 0x2C). The engine is idle after reset.
- R2: The host can write the data and enable registers at any time and read back the value it wrote. Data register k holds entry bits [32k+31:32k].
- R3: A table read (command bit 31 = 0, bit 30 = 0) loads the addressed entry into data registers 0–3. The completion flag (control bit 0) reads 1 after the third rising edge that follows the edge accepting the command, and reads 0 before that.
- R4: On a table write (command bit 31 = 1, bit 30 = 0), each stored entry bit is replaced by the data register bit where the matching enable bit is 1 and is kept where it is 0.
- R5: The completion flag stays set until the host writes the control register with bit 0 = 0. A host write with bit 0 = 1 leaves the flag unchanged.
- R6: A command write that arrives while a transfer is in progress is ignored. The command register keeps the first command, and the second command does not touch memory.
- R7: A buffer write (bits 31 = 1, 30 = 1) stores the low byte of data register 0 at the byte address in the low command bits. A buffer read (bit 31 = 0, bit 30 = 1) returns that byte zero-extended in data register 0 and leaves data registers 1–3 unchanged.
- R8: Table addresses 0x00 to 0x8F are valid, and the address is taken from command bits 29:0. A write to a larger address changes no entry, including no aliased one. A read of a larger address loads zeros into all four data registers.
- R9: Bit 30 alone selects the target. A buffer transfer leaves the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 6 | Host byte address (bits 5:2 select the register) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| xfer_done | output | 1 | Completion flag, same as control bit 0 |

## Verification
The assertions assume the following about the host:
- it drives host_wr and host_addr only as single-cycle register writes;
- it does not release reset in the middle of a transfer;
- it does not clear the completion flag in the same cycle that the flag is being set.

The bench keeps within these assumptions. It drives each register write for exactly one clock at the falling edge and waits the fixed transfer length before clearing the flag. The only overlap it creates on purpose is the busy-time command write of R6.

// File: rtl/ctab_pkg.sv
package ctab_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FETCH  = 2'd1,
        ST_APPLY  = 2'd2,
        ST_FINISH = 2'd3
    } xfer_state_t;

    // word indices of host registers (host_addr[5:2])
    localparam logic [3:0] RIDX_CTRL = 4'd0;
    localparam logic [3:0] RIDX_CMD  = 4'd1;
    localparam logic [3:0] RIDX_DATA = 4'd4;
    localparam logic [3:0] RIDX_MASK = 4'd8;

    localparam int CMD_WR_BIT  = 31;
    localparam int CMD_BUF_BIT = 30;
    localparam int CMD_ADDR_W  = 30;
    localparam int BYTE_W      = 8;
endpackage

// File: rtl/ctab_regs.sv
module ctab_regs
    import ctab_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LANES  = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           host_wr,
    input  logic [5:0]                     host_addr,
    input  logic [WORD_W-1:0]              host_wdata,
    output logic [WORD_W-1:0]              host_rdata,
    input  logic                           eng_idle,
    output logic                           start,
    output logic [WORD_W-1:0]              cmd_q,
    output logic [LANES-1:0][WORD_W-1:0]   data_q,
    output logic [LANES-1:0][WORD_W-1:0]   mask_q,
    input  logic [LANES-1:0]               load_en,
    input  logic [LANES-1:0][WORD_W-1:0]   load_data,
    input  logic                           done_set,
    output logic                           done_q
);
    logic [3:0] idx;
    logic       unused_lsb;

    assign idx        = host_addr[5:2];
    assign unused_lsb = ^host_addr[1:0];

    // a command is taken only while the engine is idle
    assign start = host_wr && (idx == RIDX_CMD) && eng_idle;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= '0;
        end else if (start) begin
            cmd_q <= host_wdata;
        end
    end

    // completion flag: set wins over a host clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
        end else if (done_set) begin
            done_q <= 1'b1;
        end else if (host_wr && (idx == RIDX_CTRL) && !host_wdata[0]) begin
            done_q <= 1'b0;
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                data_q[l] <= '0;
            end else if (load_en[l]) begin
                data_q[l] <= load_data[l];
            end else if (host_wr && (idx == RIDX_DATA + 4'(l))) begin
                data_q[l] <= host_wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_q[l] <= '0;
            end else if (host_wr && (idx == RIDX_MASK + 4'(l))) begin
                mask_q[l] <= host_wdata;
            end
        end
    end

    always_comb begin
        host_rdata = '0;
        if (idx == RIDX_CTRL) begin
            host_rdata = WORD_W'(done_q);
        end else if (idx == RIDX_CMD) begin
            host_rdata = cmd_q;
        end
        for (int l = 0; l < LANES; l++) begin
            if (idx == RIDX_DATA + 4'(l)) host_rdata = data_q[l];
            if (idx == RIDX_MASK + 4'(l)) host_rdata = mask_q[l];
        end
    end
endmodule

// File: rtl/ctab_engine.sv
module ctab_engine
    import ctab_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int LANES       = 4,
    parameter int TBL_ENTRIES = 144,
    parameter int BUF_DEPTH   = 2048,
    localparam int TBL_AW     = $clog2(TBL_ENTRIES),
    localparam int BUF_AW     = $clog2(BUF_DEPTH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           start,
    input  logic [WORD_W-1:0]              cmd_q,
    input  logic [LANES-1:0][WORD_W-1:0]   data_q,
    input  logic [LANES-1:0][WORD_W-1:0]   mask_q,
    output logic                           eng_idle,
    output logic                           tbl_rd,
    output logic                           tbl_we,
    output logic [TBL_AW-1:0]              tbl_addr,
    output logic [LANES-1:0][WORD_W-1:0]   tbl_wdata,
    input  logic [LANES-1:0][WORD_W-1:0]   tbl_rdata,
    output logic                           buf_rd,
    output logic                           buf_we,
    output logic [BUF_AW-1:0]              buf_addr,
    output logic [BYTE_W-1:0]              buf_wdata,
    input  logic [BYTE_W-1:0]              buf_rdata,
    output logic [LANES-1:0]               load_en,
    output logic [LANES-1:0][WORD_W-1:0]   load_data,
    output logic                           done_set
);
    xfer_state_t state_q, state_d;

    logic                  is_wr;
    logic                  is_buf;
    logic [CMD_ADDR_W-1:0] cmd_addr;
    logic                  in_range;

    // cmd_q only changes while idle, so it is stable for a whole transfer
    assign is_wr    = cmd_q[CMD_WR_BIT];
    assign is_buf   = cmd_q[CMD_BUF_BIT];
    assign cmd_addr = cmd_q[CMD_ADDR_W-1:0];
    assign in_range = cmd_addr < CMD_ADDR_W'(TBL_ENTRIES);

    assign tbl_addr  = cmd_addr[TBL_AW-1:0];
    assign buf_addr  = cmd_addr[BUF_AW-1:0];
    assign buf_wdata = data_q[0][BYTE_W-1:0];
    assign eng_idle  = (state_q == ST_IDLE);

    // per-lane bit merge of the fetched entry with the data registers
    for (genvar l = 0; l < LANES; l++) begin : g_merge
        assign tbl_wdata[l] = (tbl_rdata[l] & ~mask_q[l]) | (data_q[l] & mask_q[l]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_FETCH;
            ST_FETCH:  state_d = ST_APPLY;
            ST_APPLY:  state_d = ST_FINISH;
            ST_FINISH: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tbl_rd    = 1'b0;
        tbl_we    = 1'b0;
        buf_rd    = 1'b0;
        buf_we    = 1'b0;
        load_en   = '0;
        load_data = '0;
        done_set  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_FETCH: begin
                tbl_rd = !is_buf && in_range;
                buf_rd = is_buf && !is_wr;
            end
            ST_APPLY: begin
                if (is_buf) begin
                    if (is_wr) begin
                        buf_we = 1'b1;
                    end else begin
                        load_en[0]   = 1'b1;
                        load_data[0] = WORD_W'(buf_rdata);
                    end
                end else if (is_wr) begin
                    tbl_we = in_range;
                end else begin
                    load_en   = '1;
                    load_data = in_range ? tbl_rdata : '0;
                end
            end
            ST_FINISH: begin
                done_set = 1'b1;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/ctab_table_ram.sv
module ctab_table_ram #(
    parameter int WIDTH   = 128,
    parameter int ENTRIES = 144,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [ENTRIES];
    logic             hit;

    assign hit = int'(addr) < ENTRIES;

    always_ff @(posedge clk) begin
        if (wr_en && hit) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata <= hit ? mem[addr] : '0;
        end
    end
endmodule

// File: rtl/ctab_buf_ram.sv
module ctab_buf_ram #(
    parameter int DEPTH = 2048,
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rd_en,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/ctab_window.sv
module ctab_window
    import ctab_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int LANES       = 4,
    parameter int TBL_ENTRIES = 144,
    parameter int BUF_DEPTH   = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [5:0]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    output logic              xfer_done
);
    localparam int TBL_AW = $clog2(TBL_ENTRIES);
    localparam int BUF_AW = $clog2(BUF_DEPTH);

    logic                         start;
    logic                         eng_idle;
    logic [WORD_W-1:0]            cmd_q;
    logic [LANES-1:0][WORD_W-1:0] data_q;
    logic [LANES-1:0][WORD_W-1:0] mask_q;
    logic [LANES-1:0]             load_en;
    logic [LANES-1:0][WORD_W-1:0] load_data;
    logic                         done_set;
    logic                         tbl_rd;
    logic                         tbl_we;
    logic [TBL_AW-1:0]            tbl_addr;
    logic [LANES-1:0][WORD_W-1:0] tbl_wdata;
    logic [LANES-1:0][WORD_W-1:0] tbl_rdata;
    logic                         buf_rd;
    logic                         buf_we;
    logic [BUF_AW-1:0]            buf_addr;
    logic [BYTE_W-1:0]            buf_wdata;
    logic [BYTE_W-1:0]            buf_rdata;

    ctab_regs #(.WORD_W(WORD_W), .LANES(LANES)) u_regs (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .eng_idle(eng_idle),
        .start(start), .cmd_q(cmd_q), .data_q(data_q), .mask_q(mask_q),
        .load_en(load_en), .load_data(load_data), .done_set(done_set),
        .done_q(xfer_done)
    );

    ctab_engine #(
        .WORD_W(WORD_W), .LANES(LANES), .TBL_ENTRIES(TBL_ENTRIES), .BUF_DEPTH(BUF_DEPTH)
    ) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_q(cmd_q), .data_q(data_q),
        .mask_q(mask_q), .eng_idle(eng_idle), .tbl_rd(tbl_rd), .tbl_we(tbl_we),
        .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata), .tbl_rdata(tbl_rdata),
        .buf_rd(buf_rd), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
        .buf_rdata(buf_rdata), .load_en(load_en), .load_data(load_data),
        .done_set(done_set)
    );

    ctab_table_ram #(.WIDTH(LANES*WORD_W), .ENTRIES(TBL_ENTRIES)) u_tbl (
        .clk(clk), .rd_en(tbl_rd), .wr_en(tbl_we), .addr(tbl_addr),
        .wdata(tbl_wdata), .rdata(tbl_rdata)
    );

    ctab_buf_ram #(.DEPTH(BUF_DEPTH), .WIDTH(BYTE_W)) u_buf (
        .clk(clk), .rd_en(buf_rd), .wr_en(buf_we), .addr(buf_addr),
        .wdata(buf_wdata), .rdata(buf_rdata)
    );
endmodule

// File: rtl/ctab_window_chk.sv
module ctab_window_chk #(
    parameter int TBL_ENTRIES = 144,
    parameter int TBL_AW      = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic [5:0]        host_addr,
    input logic [31:0]       host_wdata,
    input logic              start,
    input logic              eng_idle,
    input logic [31:0]       cmd_q,
    input logic              done_q,
    input logic              tbl_we,
    input logic [TBL_AW-1:0] tbl_addr
);
    logic unused_chk;
    assign unused_chk = ^{host_wdata[31:1], host_addr[1:0]};

    a_r1_idle_out_of_reset: assert property (@(posedge clk)
        $rose(rst_n) |-> (eng_idle && !done_q));

    a_r3_done_on_fourth_edge: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ##4 done_q);

    a_r5_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (done_q && !(host_wr && host_addr[5:2] == 4'd0 && !host_wdata[0])) |=> done_q);

    a_r6_cmd_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_idle |=> $stable(cmd_q));

    a_r8_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        tbl_we |-> (int'(tbl_addr) < TBL_ENTRIES));
endmodule

bind ctab_window ctab_window_chk #(.TBL_ENTRIES(TBL_ENTRIES), .TBL_AW(TBL_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .start(start), .eng_idle(eng_idle), .cmd_q(cmd_q),
    .done_q(xfer_done), .tbl_we(tbl_we), .tbl_addr(tbl_addr)
);

// File: tb/sim_ctab_window.sv
module sim_ctab_window;
    localparam int NENT  = 144;
    localparam int NBUF  = 2048;
    localparam logic [5:0] A_CTRL = 6'h00;
    localparam logic [5:0] A_CMD  = 6'h04;
    localparam logic [5:0] A_DATA = 6'h10;
    localparam logic [5:0] A_MASK = 6'h20;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        host_wr;
    logic [5:0]  host_addr;
    logic [31:0] host_wdata;
    logic [31:0] host_rdata;
    logic        xfer_done;

    int          n_tests = 0;
    int          n_fail  = 0;
    logic [31:0] model [NENT][4];
    logic [31:0] v;

    always #10 clk = ~clk;

    ctab_window u0 (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .xfer_done(xfer_done)
    );

    function automatic logic [31:0] pat(int a, int l, int salt);
        return {8'(a), 8'(l + salt), 8'(a * 3 + l), 8'(~a ^ salt)};
    endfunction

    function automatic logic [31:0] mk(int a, int l);
        return (32'(a) * 32'h9E3779B9) ^ (32'(l + 1) * 32'h7F4A7C15);
    endfunction

    function automatic logic [7:0] bpat(int a);
        return 8'(a * 7 + 3 + (a >> 8));
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hr(input logic [5:0] a, output logic [31:0] d);
        host_addr = a;
        #1;
        d = host_rdata;
    endtask

    task automatic xfer(input logic [31:0] cmd);
        hw(A_CMD, cmd);
        repeat (3) @(negedge clk);
        hw(A_CTRL, 32'h0);
    endtask

    task automatic tbl_read_check(input int a, input string tag);
        xfer({2'b00, 30'(a)});
        for (int l = 0; l < 4; l++) begin
            hr(A_DATA + 6'(4 * l), v);
            chk(tag, v, model[a][l]);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; host_wr = 1'b0; host_addr = '0; host_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        hr(A_CTRL, v); chk("R1 ctrl", v, 32'h0);
        hr(A_CMD, v);  chk("R1 cmd", v, 32'h0);
        for (int l = 0; l < 4; l++) begin
            hr(A_DATA + 6'(4 * l), v); chk("R1 data", v, 32'h0);
            hr(A_MASK + 6'(4 * l), v); chk("R1 mask", v, 32'h0);
        end

        // R2: register write and readback
        for (int l = 0; l < 4; l++) begin
            hw(A_DATA + 6'(4 * l), pat(l, l, 9));
            hw(A_MASK + 6'(4 * l), mk(l, l));
        end
        for (int l = 0; l < 4; l++) begin
            hr(A_DATA + 6'(4 * l), v); chk("R2 data", v, pat(l, l, 9));
            hr(A_MASK + 6'(4 * l), v); chk("R2 mask", v, mk(l, l));
        end

        // R4: fill every entry with full enables
        for (int l = 0; l < 4; l++) hw(A_MASK + 6'(4 * l), 32'hFFFF_FFFF);
        for (int a = 0; a < NENT; a++) begin
            for (int l = 0; l < 4; l++) begin
                hw(A_DATA + 6'(4 * l), pat(a, l, 1));
                model[a][l] = pat(a, l, 1);
            end
            xfer({2'b10, 30'(a)});
        end

        // R3: exact completion latency on a table read
        hw(A_CMD, {2'b00, 30'd5});
        hr(A_CTRL, v); chk("R3 busy edge1", v, 32'h0);
        @(negedge clk); hr(A_CTRL, v); chk("R3 busy edge2", v, 32'h0);
        @(negedge clk); hr(A_CTRL, v); chk("R3 busy edge3", v, 32'h0);
        @(negedge clk); hr(A_CTRL, v); chk("R3 done edge3", v, 32'h1);
        for (int l = 0; l < 4; l++) begin
            hr(A_DATA + 6'(4 * l), v); chk("R3 entry5", v, model[5][l]);
        end

        // R5: writing 1 keeps the flag, writing 0 clears it
        hw(A_CTRL, 32'h1); hr(A_CTRL, v); chk("R5 keep", v, 32'h1);
        chk("R5 port", {31'b0, xfer_done}, 32'h1);
        hw(A_CTRL, 32'h0); hr(A_CTRL, v); chk("R5 clear", v, 32'h0);

        // R3: read back all entries
        for (int a = 0; a < NENT; a++) tbl_read_check(a, "R3 sweep");

        // R4: masked merge on every entry
        for (int a = 0; a < NENT; a++) begin
            for (int l = 0; l < 4; l++) begin
                hw(A_DATA + 6'(4 * l), ~pat(a, l, 2));
                hw(A_MASK + 6'(4 * l), mk(a, l));
                model[a][l] = (model[a][l] & ~mk(a, l)) | (~pat(a, l, 2) & mk(a, l));
            end
            xfer({2'b10, 30'(a)});
        end
        for (int a = 0; a < NENT; a++) tbl_read_check(a, "R4 merge");

        // R8: out-of-range write and read
        for (int l = 0; l < 4; l++) begin
            hw(A_MASK + 6'(4 * l), 32'hFFFF_FFFF);
            hw(A_DATA + 6'(4 * l), 32'hBAD0_0000 + 32'(l));
        end
        xfer({2'b10, 30'h90});
        xfer({2'b10, 30'h100});
        xfer({2'b10, 30'h110});
        xfer({2'b00, 30'h90});
        for (int l = 0; l < 4; l++) begin
            hr(A_DATA + 6'(4 * l), v); chk("R8 oob read zero", v, 32'h0);
        end
        tbl_read_check(0, "R8 no alias 0x100");
        tbl_read_check(16, "R8 no alias 0x110");
        tbl_read_check(NENT - 1, "R8 last entry");

        // R6: command while busy is ignored
        for (int l = 0; l < 4; l++) hw(A_DATA + 6'(4 * l), 32'h6666_0000 + 32'(l));
        hw(A_CMD, {2'b10, 30'd20});
        hw(A_CMD, {2'b10, 30'd21});
        hr(A_CMD, v); chk("R6 cmd kept", v, {2'b10, 30'd20});
        repeat (3) @(negedge clk);
        hw(A_CTRL, 32'h0);
        for (int l = 0; l < 4; l++) model[20][l] = 32'h6666_0000 + 32'(l);
        tbl_read_check(20, "R6 first done");
        tbl_read_check(21, "R6 second ignored");

        // R7: buffer write sweep with junk in upper bits
        for (int a = 0; a < NBUF; a++) begin
            hw(A_DATA, {24'hDEADBE, bpat(a)});
            xfer({2'b11, 30'(a)});
        end
        for (int l = 1; l < 4; l++) hw(A_DATA + 6'(4 * l), 32'hC0DE_0000 + 32'(l));
        for (int a = 0; a < NBUF; a++) begin
            xfer({2'b01, 30'(a)});
            hr(A_DATA, v); chk("R7 byte zero-ext", v, {24'h0, bpat(a)});
        end
        for (int l = 1; l < 4; l++) begin
            hr(A_DATA + 6'(4 * l), v); chk("R7 upper data kept", v, 32'hC0DE_0000 + 32'(l));
        end

        // R9: buffer traffic left the table alone
        tbl_read_check(5, "R9 table untouched");
        tbl_read_check(0, "R9 table untouched");

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule